// File: doc/BRIEF.md
# Generalized Reverse and OR-Combine Execution Unit

This block is a purely combinational execution unit for a 64-bit core. It takes one instruction word and two 64-bit register operands, and it returns a 64-bit result and a flag that marks the word as one it does not recognise. It handles two bit-permutation families.

The first family is generalized reverse. A sequence of stages swaps neighbouring bit groups of size 1, 2, 4, 8, 16 and 32. The second family is generalized OR-combine. It uses the same stages, but each stage ORs the swapped copy into the running value instead of replacing it. Each stage is switched on by one bit of a control value. That value comes either from the second operand or from an immediate field.

Each family has four forms:
- a register form;
- an immediate form;
- a register form that works on the low 32 bits only;
- an immediate form that works on the low 32 bits only.

The byte-wise OR-combine is the immediate OR-combine with control value 7. It turns every nonzero byte into 0xFF and leaves every zero byte as 0x00, which makes it useful for string scanning.

A core places the unit in its execute stage beside the ALU. The core routes decoded operands in and writes the result back.

Top module: `grevOrcUnit`

## Requirements
- R1: The register-form reverse (bits[31:25]=0110100, bits[14:12]=101, bits[6:0]=0110011) runs stages k=0..5, in that order, with distance 2^k. Stage k is active only when control bit k is set. An active stage replaces x with ((x & M_k) << 2^k) | ((x >> 2^k) & M_k). Bit j of M_k is set when bit k of j is 0. The control value is srcB[5:0].
- R2: The register-form OR-combine (bits[31:25]=0010100, bits[14:12]=101, bits[6:0]=0110011) uses the same stages as R1, except that an active stage sets x to x OR the swapped value. The result therefore keeps every set bit of srcA.
- R3: The immediate forms (bits[14:12]=101, bits[6:0]=0010011) are reverse when bits[31:26]=011010 and OR-combine when bits[31:26]=001010. They take the control value from bits[25:20], and srcB has no effect on the result.
- R4: The word bits[31:20]=001010000111, bits[14:12]=101, bits[6:0]=0010011 gives a result whose byte n is 0xFF when byte n of srcA is nonzero and 0x00 otherwise.
- R5: The word register forms (bits[6:0]=0111011, bits[14:12]=101, bits[31:25] as in R1/R2) apply the R1/R2 stages to srcA[31:0] with stages 0..4 only, using srcB[4:0]. The result is that 32-bit value sign-extended from bit 31.
- R6: The word immediate forms (bits[6:0]=0011011, bits[14:12]=101, bits[31:25]=0110100 for reverse or 0010100 for OR-combine) behave as R5 with the control value taken from bits[24:20].
- R7: Operand bits above the control field have no effect on the result. These are srcB[63:6] for the register forms and srcB[63:5] for the word register forms.
- R8: Any instruction word matching none of the encodings above drives illegal high and result to zero. A matching word drives illegal low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| srcA | input | 64 | Operand to be permuted |
| srcB | input | 64 | Control operand for the register forms |
| result | output | 64 | Permuted or combined value, zero when illegal |
| illegal | output | 1 | High when the word matches no supported encoding |

## Verification
The bench builds the unit with its default 64-bit width. At that width all six stages, including the 32-bit half swap, can be reached, and the word forms can be compared against a narrower five-stage loop. The random mix of control values covers every combination of the active stages. Fully random instruction words cover the illegal space and the near-miss encodings around the legal ones.

// File: rtl/grev_orc_pkg.sv
package grev_orc_pkg;
  parameter int GO_XLEN = 64;
  localparam int GO_STAGES = $clog2(GO_XLEN);
  localparam int GO_WLEN = GO_XLEN / 2;

  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM_W  = 7'b0011011;
  localparam logic [6:0] OPC_REG_W  = 7'b0111011;
  localparam logic [2:0] F3_PERM    = 3'b101;
  localparam logic [6:0] F7_REV     = 7'b0110100;
  localparam logic [6:0] F7_COMB    = 7'b0010100;
  localparam logic [5:0] F6_REV_IMM = 6'b011010;
  localparam logic [5:0] F6_COMB_IMM = 6'b001010;

  typedef struct packed {
    logic                 legal;
    logic                 isOrc;
    logic                 word;
    logic [GO_STAGES-1:0] ctrl;
  } grevCtl_t;

  function automatic logic [GO_XLEN-1:0] stageMask(input int stage);
    logic [GO_XLEN-1:0] m;
    for (int j = 0; j < GO_XLEN; j++) m[j] = ((j >> stage) & 1) == 0;
    return m;
  endfunction
endpackage

// File: rtl/grevOrcDecode.sv
module grevOrcDecode
  import grev_orc_pkg::*;
(
  input  logic [31:0]          instrWord,
  input  logic [GO_STAGES-1:0] ctrlReg,
  output grevCtl_t             ctl
);
  localparam int SH_LO = 20;

  logic [6:0] opcode;
  logic       f3Ok;
  logic [6:0] f7;
  logic [5:0] f6;

  assign opcode = instrWord[6:0];
  assign f3Ok   = instrWord[14:12] == F3_PERM;
  assign f7     = instrWord[31:25];
  assign f6     = instrWord[31:26];

  always_comb begin
    ctl = '0;
    if (f3Ok) begin
      case (opcode)
        OPC_IMM: begin
          if (f6 == F6_COMB_IMM || f6 == F6_REV_IMM) begin
            ctl.legal = 1'b1;
            ctl.isOrc = (f6 == F6_COMB_IMM);
            ctl.ctrl  = instrWord[SH_LO +: GO_STAGES];
          end
        end
        OPC_REG: begin
          if (f7 == F7_COMB || f7 == F7_REV) begin
            ctl.legal = 1'b1;
            ctl.isOrc = (f7 == F7_COMB);
            ctl.ctrl  = ctrlReg;
          end
        end
        OPC_REG_W: begin
          if (f7 == F7_COMB || f7 == F7_REV) begin
            ctl.legal = 1'b1;
            ctl.word  = 1'b1;
            ctl.isOrc = (f7 == F7_COMB);
            ctl.ctrl  = {1'b0, ctrlReg[GO_STAGES-2:0]};
          end
        end
        OPC_IMM_W: begin
          if (f7 == F7_COMB || f7 == F7_REV) begin
            ctl.legal = 1'b1;
            ctl.word  = 1'b1;
            ctl.isOrc = (f7 == F7_COMB);
            ctl.ctrl  = {1'b0, instrWord[SH_LO +: GO_STAGES-1]};
          end
        end
        default: ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/grevOrcDatapath.sv
module grevOrcDatapath
  import grev_orc_pkg::*;
(
  input  logic [GO_XLEN-1:0] opA,
  input  grevCtl_t           ctl,
  output logic [GO_XLEN-1:0] res
);
  logic [GO_XLEN-1:0] stageVal [0:GO_STAGES];

  // word forms see a zero-extended low half; the half swap is never enabled for them
  assign stageVal[0] = ctl.word ? {{GO_WLEN{1'b0}}, opA[GO_WLEN-1:0]} : opA;

  for (genvar s = 0; s < GO_STAGES; s++) begin : g_stage
    localparam int DIST = 1 << s;
    localparam logic [GO_XLEN-1:0] MASK = stageMask(s);
    logic [GO_XLEN-1:0] swapped;
    assign swapped = ((stageVal[s] & MASK) << DIST) | ((stageVal[s] >> DIST) & MASK);
    assign stageVal[s+1] = !ctl.ctrl[s] ? stageVal[s]
                         : (ctl.isOrc ? (stageVal[s] | swapped) : swapped);
  end

  always_comb begin
    if (!ctl.legal)
      res = '0;
    else if (ctl.word)
      res = {{GO_WLEN{stageVal[GO_STAGES][GO_WLEN-1]}}, stageVal[GO_STAGES][GO_WLEN-1:0]};
    else
      res = stageVal[GO_STAGES];
  end
endmodule

// File: rtl/grevOrcUnit.sv
module grevOrcUnit
  import grev_orc_pkg::*;
(
  input  logic [31:0]        instrWord,
  input  logic [GO_XLEN-1:0] srcA,
  input  logic [GO_XLEN-1:0] srcB,
  output logic [GO_XLEN-1:0] result,
  output logic               illegal
);
  grevCtl_t ctl;
  logic     unusedHigh;

  assign unusedHigh = ^srcB[GO_XLEN-1:GO_STAGES];

  grevOrcDecode u_dec (
    .instrWord(instrWord),
    .ctrlReg  (srcB[GO_STAGES-1:0]),
    .ctl      (ctl)
  );

  grevOrcDatapath u_dp (
    .opA(srcA),
    .ctl(ctl),
    .res(result)
  );

  assign illegal = !ctl.legal;
endmodule

// File: rtl/grevOrcChecker.sv
module grevOrcChecker
  import grev_orc_pkg::*;
(
  input logic [31:0]        instrWord,
  input logic [GO_XLEN-1:0] srcA,
  input logic [GO_XLEN-1:0] result,
  input logic               illegal,
  input grevCtl_t           ctl
);
  logic isByteComb;
  assign isByteComb = instrWord[31:20] == 12'b001010000111 &&
                      instrWord[14:12] == 3'b101 && instrWord[6:0] == 7'b0010011;

  always_comb begin
    if (illegal) a_r8_illegal_zero: assert (result == '0);
    a_r8_flag_vs_decode: assert (illegal == !ctl.legal);
    if (!illegal && ctl.isOrc && !ctl.word)
      a_r2_keeps_source_bits: assert ((result & srcA) == srcA);
    if (!illegal && !ctl.isOrc && !ctl.word)
      a_r1_popcount_kept: assert ($countones(result) == $countones(srcA));
    if (!illegal && ctl.word)
      a_r5_sign_extended: assert (result[GO_XLEN-1:GO_WLEN] == {GO_WLEN{result[GO_WLEN-1]}});
    if (isByteComb) begin
      a_r4_legal: assert (!illegal);
      for (int b = 0; b < GO_XLEN / 8; b++)
        a_r4_byte_value: assert (result[8*b +: 8] == ((srcA[8*b +: 8] != 8'h00) ? 8'hFF : 8'h00));
    end
  end
endmodule

bind grevOrcUnit grevOrcChecker u_chk (
  .instrWord(instrWord),
  .srcA     (srcA),
  .result   (result),
  .illegal  (illegal),
  .ctl      (ctl)
);

// File: tb/sim_grevOrcUnit.sv
module sim_grevOrcUnit;
  logic        clk = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] srcA = '0, srcB = '0;
  logic [63:0] result;
  logic        illegal;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  grevOrcUnit u0 (.instrWord(instrWord), .srcA(srcA), .srcB(srcB),
                  .result(result), .illegal(illegal));

  function automatic logic [63:0] refPerm(logic [63:0] x, int c, int width, bit orc);
    logic [63:0] v = x;
    for (int i = 0; (1 << i) < width; i++) begin
      if ((c >> i) & 1) begin
        logic [63:0] m, sw;
        int d = 1 << i;
        for (int j = 0; j < 64; j++) m[j] = ((j >> i) & 1) == 0;
        sw = ((v & m) << d) | ((v >> d) & m);
        v = orc ? (v | sw) : sw;
      end
    end
    return v;
  endfunction

  function automatic void refExec(logic [31:0] iw, logic [63:0] a, logic [63:0] b,
                                  output logic [63:0] r, output logic ill);
    logic [6:0] opc = iw[6:0];
    logic [6:0] f7 = iw[31:25];
    logic [5:0] f6 = iw[31:26];
    logic [63:0] lo;
    ill = 1'b1; r = '0;
    if (iw[14:12] != 3'b101) return;
    lo = {32'b0, a[31:0]};
    if (opc == 7'b0010011 && (f6 == 6'b001010 || f6 == 6'b011010)) begin
      ill = 0; r = refPerm(a, int'(iw[25:20]), 64, f6 == 6'b001010);
    end else if (opc == 7'b0110011 && (f7 == 7'b0010100 || f7 == 7'b0110100)) begin
      ill = 0; r = refPerm(a, int'(b[5:0]), 64, f7 == 7'b0010100);
    end else if ((opc == 7'b0111011 || opc == 7'b0011011) && (f7 == 7'b0010100 || f7 == 7'b0110100)) begin
      ill = 0;
      r = refPerm(lo, (opc == 7'b0111011) ? int'(b[4:0]) : int'(iw[24:20]), 32, f7 == 7'b0010100);
      r = {{32{r[31]}}, r[31:0]};
    end
  endfunction

  function automatic logic [31:0] enc(logic [6:0] top, logic [4:0] f2, logic [6:0] opc);
    return {top, f2, 5'($urandom), 3'b101, 5'($urandom), opc};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] iw, logic [63:0] a, logic [63:0] b, string tag);
    logic [63:0] er; logic ei;
    @(negedge clk);
    instrWord = iw; srcA = a; srcB = b;
    @(posedge clk); #1;
    refExec(iw, a, b, er, ei);
    chk({tag, " result"}, result, er);
    chk({tag, " illegal"}, {63'b0, illegal}, {63'b0, ei});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd20210911));
    @(posedge clk); #1;
    chk("R8 reset-state result", result, 64'h0);
    chk("R8 reset-state illegal", {63'b0, illegal}, 64'h1);

    // R4 byte OR-combine directed
    apply({12'b001010000111, 5'd3, 3'b101, 5'd4, 7'b0010011}, 64'h00FF0010_00000001, 64'h0, "R4");
    chk("R4 bytes", result, 64'h00FF00FF_000000FF);
    apply({12'b001010000111, 5'd3, 3'b101, 5'd4, 7'b0010011}, 64'h0, 64'hFFFF, "R4 zero");
    // R1 full reverse
    apply(enc(7'b0110100, 5'd2, 7'b0110011), 64'h1, 64'd63, "R1");
    chk("R1 bit reverse", result, 64'h80000000_00000000);
    // R2 full combine
    apply(enc(7'b0010100, 5'd2, 7'b0110011), 64'h10, 64'd63, "R2");
    chk("R2 all ones", result, 64'hFFFFFFFF_FFFFFFFF);
    // R7 high control bits ignored
    apply(enc(7'b0110100, 5'd2, 7'b0110011), 64'h12345678_9ABCDEF0, 64'hFFFFFFFF_FFFFFFC0, "R7");
    chk("R7 no-op", result, 64'h12345678_9ABCDEF0);
    apply(enc(7'b0010100, 5'd2, 7'b0111011), 64'hFFFF0000_00000001, 64'h20, "R7 word");
    chk("R7 word no-op", result, 64'h1);
    // R5/R6 word combine sign-extends
    apply(enc(7'b0010100, 5'd2, 7'b0111011), 64'h1, 64'd31, "R5");
    chk("R5 sext", result, 64'hFFFFFFFF_FFFFFFFF);
    apply({7'b0110100, 5'd31, 5'd1, 3'b101, 5'd2, 7'b0011011}, 64'hAAAA0000_00000001, 64'h0, "R6");
    chk("R6 reverse", result, 64'hFFFFFFFF_80000000);
    // R3 srcB has no effect on immediate form
    apply({6'b011010, 6'd21, 5'd1, 3'b101, 5'd2, 7'b0010011}, 64'h0123_4567_89AB_CDEF, 64'h0, "R3 b0");
    keep = result;
    apply({6'b011010, 6'd21, 5'd1, 3'b101, 5'd2, 7'b0010011}, 64'h0123_4567_89AB_CDEF, '1, "R3 b1");
    chk("R3 srcB ignored", result, keep);
    // R8 near misses
    apply({7'b0110100, 5'd2, 5'd1, 3'b001, 5'd2, 7'b0110011}, '1, 64'd5, "R8 funct3");
    apply({7'b0110101, 5'd2, 5'd1, 3'b101, 5'd2, 7'b0110011}, '1, 64'd5, "R8 funct7");

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic top = $urandom % 2;
      case ($urandom % 7)
        0: apply(enc(top ? 7'b0010100 : 7'b0110100, 5'($urandom), 7'b0110011), a, b, "R1/R2 reg");
        1: apply({top ? 6'b001010 : 6'b011010, 6'($urandom), 5'($urandom), 3'b101, 5'($urandom), 7'b0010011}, a, b, "R3 imm");
        2: apply(enc(top ? 7'b0010100 : 7'b0110100, 5'($urandom), 7'b0111011), a, b, "R5 word reg");
        3: apply(enc(top ? 7'b0010100 : 7'b0110100, 5'($urandom), 7'b0011011), a, b, "R6 word imm");
        4: apply({12'b001010000111, 5'($urandom), 3'b101, 5'($urandom), 7'b0010011},
                 a & {8{{7'b0, top}}} , b, "R4 orc byte");
        5: apply({$urandom} | 32'h0000_5000, a, b, "R8 random");
        default: apply($urandom, a, b, "R8 random");
      endcase
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule